// File: doc/BRIEF.md
# Low-Order Interleaved Four-Bank Memory

This block is a main-memory subsystem that refills cache lines. Its storage is split into four banks that work independently. The two least significant bits of a word address pick the bank, and the remaining bits pick the row inside that bank. Words at adjacent addresses therefore sit in adjacent banks, wrapping from bank 3 back to bank 0.

On a block read, every bank starts its row access in the same cycle. After one address cycle and one shared access latency, the one-word bus returns the whole line in ascending address order, one word per cycle. The block also performs single-word reads and single-word writes. A single write touches only the bank named by the low address bits.

After each operation the block reports two cycle counts. The first is the number of cycles the operation actually took. The second is the number a one-word-wide memory without interleaving would need for the same number of words. A test can compare the two directly.

Top module: `ilv_mem`

## Requirements
- R1: For word address A, the bank is A[1:0] and the row inside the bank is A[ADDR_W-1:2]. Data written at any address is returned unchanged by a later read of that address.
- R2: Some cycles after `rst_n` is released, the block shows the following: `req_ready` is 1, `rd_valid`, `rd_last` and `wr_ack` are 0, and both cycle counts are 0.
- R3: A block read is accepted at the clock edge where `req_valid` and `req_ready` are both high. Call the first cycle after that edge cycle 0. `rd_valid` is then high in cycles ACCESS_LAT+1 through ACCESS_LAT+BLOCK_WORDS inclusive, and low in every other cycle of the operation. `rd_last` is high only in the final beat.
- R4: A block read returns the BLOCK_WORDS words starting at the request address with its low log2(BLOCK_WORDS) bits forced to zero. The words come in ascending address order, so any misalignment in the request address is ignored.
- R5: A single read returns one word, in cycle ACCESS_LAT+1, with `rd_last` high in that same cycle.
- R6: A single write stores `req_wdata` only at the addressed word. `wr_ack` is high in cycle ACCESS_LAT+1 alone, and `rd_valid` stays low for the whole write.
- R7: `req_ready` goes low from the cycle after acceptance until the operation's final transfer cycle has completed. Any request presented while `req_ready` is low has no effect.
- R8: When an operation completes, `cyc_count` is set to the cycles the operation took. A block read takes 1+ACCESS_LAT+BLOCK_WORDS cycles. A single read or write takes 2+ACCESS_LAT cycles. `cyc_serial` is set to (words moved)×(2+ACCESS_LAT).
- R9: The operation is selected by `req_op`. The value 00 is a single read and 01 is a single write. Any value with bit 1 set is a block read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation select (R9) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | Read word present on `rd_data` |
| rd_last | output | 1 | Final word of the current read |
| rd_data | output | DATA_W | Read word |
| wr_ack | output | 1 | Write transfer cycle |
| cyc_count | output | CYC_W | Measured cycles of the last completed operation |
| cyc_serial | output | CYC_W | Cycles a non-interleaved one-word memory would need for it |

## Verification
The assertions check the following on every cycle:
- the read strobe never appears while the block is ready;
- a write acknowledge and a read strobe never coincide;
- an accepted request drops ready on the next cycle;
- no read run grows longer than a block, and the block-th beat of a run always carries the last flag;
- the reported cycle count holds still while the block is idle.

Only the bench's scenarios can show the rest. These are the exact cycle at which the first word appears, the data itself and its ascending order, the bank mapping behind it, the alignment of misaligned block addresses, and that a request made while busy leaves memory unchanged.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } ilv_state_e;

  typedef enum logic [1:0] {
    K_RD  = 2'd0,
    K_WR  = 2'd1,
    K_BLK = 2'd2
  } ilv_kind_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 6,
  parameter int WPB    = 2,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ROW_W-1:0]             wr_row,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         ld_en,
  input  logic [ROW_W-1:0]             ld_row,
  output logic [WPB-1:0][DATA_W-1:0]   buf_q
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [WPB-1:0][DATA_W-1:0] buf_d;

  // storage array, written only on this bank's write strobe
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  // fetch buffer: this bank's share of a line, consecutive rows
  always_comb begin
    buf_d = buf_q;
    for (int k = 0; k < WPB; k++) begin
      buf_d[k] = mem[ld_row + ROW_W'(k)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (ld_en) begin
      buf_q <= buf_d;
    end
  end

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 8,
  parameter int ACCESS_LAT  = 3,
  parameter int CYC_W       = 8,
  localparam int BANK_BITS  = $clog2(NUM_BANKS),
  localparam int ROW_W      = ADDR_W - BANK_BITS,
  localparam int IDX_W      = $clog2(BLOCK_WORDS),
  localparam int LAT_W      = $clog2(ACCESS_LAT + 1),
  localparam int NB_W       = $clog2(BLOCK_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  ld_en,
  output logic [ROW_W-1:0]      ld_row,
  output logic                  wr_en,
  output logic [ROW_W-1:0]      wr_row,
  output logic [BANK_BITS-1:0]  wr_bank,
  output logic [DATA_W-1:0]     wr_data,
  output logic [IDX_W-1:0]      word_idx,
  output logic                  rd_valid,
  output logic                  rd_last,
  output logic                  wr_ack,
  output logic [CYC_W-1:0]      cyc_count,
  output logic [NB_W-1:0]       last_beats
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_WORDS - 1);

  ilv_state_e             st_q, st_d;
  ilv_kind_e              kind_q, kind_d;
  logic [ROW_W-1:0]       row_q, row_d;
  logic [BANK_BITS-1:0]   bank_q, bank_d;
  logic [DATA_W-1:0]      wdata_q, wdata_d;
  logic [LAT_W-1:0]       cnt_q, cnt_d;
  logic [IDX_W-1:0]       beat_q, beat_d;
  logic [CYC_W-1:0]       run_q, run_d;
  logic [CYC_W-1:0]       cyc_q, cyc_d;
  logic [NB_W-1:0]        nb_q, nb_d;

  logic                   accept;
  logic                   cap_en;
  logic                   done;
  logic                   acc_end;
  logic [ADDR_W-1:0]      aligned_addr;
  logic [IDX_W-1:0]       last_beat;

  assign accept       = (st_q == ST_IDLE) && req_valid;
  assign aligned_addr = req_addr & ALIGN_MASK;
  assign last_beat    = (kind_q == K_BLK) ? IDX_W'(BLOCK_WORDS - 1) : '0;
  assign acc_end      = (st_q == ST_ACC) && (cnt_q == LAT_W'(ACCESS_LAT - 1));
  assign done         = (st_q == ST_XFER) && (beat_q == last_beat);
  assign cap_en       = accept;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    run_d   = run_q;
    cyc_d   = cyc_q;
    nb_d    = nb_q;
    kind_d  = kind_q;
    row_d   = row_q;
    bank_d  = bank_q;
    wdata_d = wdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_ADDR;
          beat_d  = '0;
          run_d   = '0;
          wdata_d = req_wdata;
          if (req_op[1]) begin
            kind_d = K_BLK;
            row_d  = aligned_addr[ADDR_W-1:BANK_BITS];
            bank_d = '0;
          end else begin
            kind_d = req_op[0] ? K_WR : K_RD;
            row_d  = req_addr[ADDR_W-1:BANK_BITS];
            bank_d = req_addr[BANK_BITS-1:0];
          end
        end
      end
      ST_ADDR: begin
        st_d  = ST_ACC;
        cnt_d = '0;
        run_d = run_q + 1'b1;
      end
      ST_ACC: begin
        run_d = run_q + 1'b1;
        if (acc_end) begin
          st_d = ST_XFER;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        run_d = run_q + 1'b1;
        if (done) begin
          st_d  = ST_IDLE;
          cyc_d = run_q + 1'b1;
          nb_d  = (kind_q == K_BLK) ? NB_W'(BLOCK_WORDS) : NB_W'(1);
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      run_q  <= '0;
      cyc_q  <= '0;
      nb_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      run_q  <= run_d;
      cyc_q  <= cyc_d;
      nb_q   <= nb_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_RD;
      row_q   <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      kind_q  <= kind_d;
      row_q   <= row_d;
      bank_q  <= bank_d;
      wdata_q <= wdata_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign ld_en      = acc_end;
  assign ld_row     = row_q;
  assign wr_en      = (st_q == ST_XFER) && (kind_q == K_WR);
  assign wr_row     = row_q;
  assign wr_bank    = bank_q;
  assign wr_data    = wdata_q;
  assign word_idx   = beat_q + IDX_W'(bank_q);
  assign rd_valid   = (st_q == ST_XFER) && (kind_q != K_WR);
  assign rd_last    = rd_valid && (beat_q == last_beat);
  assign wr_ack     = wr_en;
  assign cyc_count  = cyc_q;
  assign last_beats = nb_q;

endmodule

// File: rtl/ilv_beat_mux.sv
module ilv_beat_mux #(
  parameter int DATA_W      = 16,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 8,
  localparam int BANK_BITS  = $clog2(NUM_BANKS),
  localparam int WPB        = BLOCK_WORDS / NUM_BANKS,
  localparam int IDX_W      = $clog2(BLOCK_WORDS),
  localparam int SLOT_W     = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic [NUM_BANKS-1:0][WPB-1:0][DATA_W-1:0] bank_bufs,
  input  logic [IDX_W-1:0]                          word_idx,
  input  logic                                      en,
  output logic [DATA_W-1:0]                         data
);

  logic [BANK_BITS-1:0] bank_sel;
  logic [SLOT_W-1:0]    slot_sel;

  // low index bits name the bank, the rest name the slot in its buffer
  assign bank_sel = word_idx[BANK_BITS-1:0];
  assign slot_sel = SLOT_W'(word_idx >> BANK_BITS);

  always_comb begin
    data = '0;
    if (en) begin
      data = bank_bufs[bank_sel][slot_sel];
    end
  end

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 8,
  parameter int ACCESS_LAT  = 3,
  parameter int CYC_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic                 rd_last,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 wr_ack,
  output logic [CYC_W-1:0]     cyc_count,
  output logic [CYC_W-1:0]     cyc_serial
);

  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS;
  localparam int WPB       = BLOCK_WORDS / NUM_BANKS;
  localparam int IDX_W     = $clog2(BLOCK_WORDS);
  localparam int NB_W      = $clog2(BLOCK_WORDS + 1);

  logic [1:0]                              rst_sync_q;
  logic                                    rst_int_n;
  logic                                    ld_en;
  logic [ROW_W-1:0]                        ld_row;
  logic                                    wr_en;
  logic [ROW_W-1:0]                        wr_row;
  logic [BANK_BITS-1:0]                    wr_bank;
  logic [DATA_W-1:0]                       wr_data;
  logic [IDX_W-1:0]                        word_idx;
  logic [NB_W-1:0]                         last_beats;
  logic [NUM_BANKS-1:0]                    bank_wr;
  logic [NUM_BANKS-1:0][WPB-1:0][DATA_W-1:0] bank_bufs;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ilv_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_BANKS   (NUM_BANKS),
    .BLOCK_WORDS (BLOCK_WORDS),
    .ACCESS_LAT  (ACCESS_LAT),
    .CYC_W       (CYC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .ld_en      (ld_en),
    .ld_row     (ld_row),
    .wr_en      (wr_en),
    .wr_row     (wr_row),
    .wr_bank    (wr_bank),
    .wr_data    (wr_data),
    .word_idx   (word_idx),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .wr_ack     (wr_ack),
    .cyc_count  (cyc_count),
    .last_beats (last_beats)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_wr[g] = wr_en && (wr_bank == BANK_BITS'(g));

    ilv_bank #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W),
      .WPB    (WPB)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (bank_wr[g]),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .ld_en   (ld_en),
      .ld_row  (ld_row),
      .buf_q   (bank_bufs[g])
    );
  end

  ilv_beat_mux #(
    .DATA_W      (DATA_W),
    .NUM_BANKS   (NUM_BANKS),
    .BLOCK_WORDS (BLOCK_WORDS)
  ) u_mux (
    .bank_bufs (bank_bufs),
    .word_idx  (word_idx),
    .en        (rd_valid),
    .data      (rd_data)
  );

  assign cyc_serial = CYC_W'(last_beats) * CYC_W'(ACCESS_LAT + 2);

endmodule

// File: rtl/ilv_mem_checker.sv
module ilv_mem_checker #(
  parameter int BLOCK_WORDS = 8,
  parameter int CYC_W       = 8,
  localparam int RUN_W      = $clog2(BLOCK_WORDS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             wr_ack,
  input logic [CYC_W-1:0] cyc_count
);

  logic [RUN_W-1:0] run_q;

  // beats already seen in the current read run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (rd_valid && !rd_last) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  assert_busy_when_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

  assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ack_excludes_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && rd_valid));

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(run_q) < BLOCK_WORDS));

  assert_run_end_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && int'(run_q) == BLOCK_WORDS - 1) |-> rd_last);

  assert_count_held_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(cyc_count));

endmodule

bind ilv_mem ilv_mem_checker #(
  .BLOCK_WORDS (BLOCK_WORDS),
  .CYC_W       (CYC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .wr_ack    (wr_ack),
  .cyc_count (cyc_count)
);

// File: tb/tb_ilv_mem.sv
module tb_ilv_mem;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NB     = 4;
  localparam int N      = 8;
  localparam int LAT    = 3;
  localparam int CYC_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_ready;
  logic              rd_valid;
  logic              rd_last;
  logic [DATA_W-1:0] rd_data;
  logic              wr_ack;
  logic [CYC_W-1:0]  cyc_count;
  logic [CYC_W-1:0]  cyc_serial;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] model [DEPTH];

  ilv_mem #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .NUM_BANKS (NB),
    .BLOCK_WORDS (N), .ACCESS_LAT (LAT), .CYC_W (CYC_W)
  ) dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
    .rd_valid (rd_valid), .rd_last (rd_last), .rd_data (rd_data),
    .wr_ack (wr_ack), .cyc_count (cyc_count), .cyc_serial (cyc_serial)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int words_of(input logic [1:0] op);
    return op[1] ? N : 1;
  endfunction

  function automatic logic [ADDR_W-1:0] first_addr(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    return op[1] ? (a & ~ADDR_W'(N - 1)) : a;
  endfunction

  // one operation from acceptance to completion, checked cycle by cycle
  task automatic run_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input bit inject,
                        input logic [ADDR_W-1:0] inj_addr);
    int beats;
    logic [ADDR_W-1:0] base;
    string tv;
    beats = words_of(op);
    base  = first_addr(op, a);
    tv    = op[1] ? "R3" : (op[0] ? "R6" : "R5");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 0; i <= LAT + beats + 1; i++) begin
      @(negedge clk);
      if (inject && i == 1) begin
        req_valid = 1'b1; req_op = 2'b01; req_addr = inj_addr; req_wdata = 16'hDEAD;
      end
      if (inject && i == 3) req_valid = 1'b0;
      if (i == LAT + beats + 1) begin
        check("R7 ready after completion", {31'd0, req_ready}, 32'd1);
        check("R8 measured cycles", {24'd0, cyc_count},
              32'(op[1] ? 1 + LAT + N : 2 + LAT));
        check("R8 serial cycles", {24'd0, cyc_serial}, 32'(beats * (2 + LAT)));
      end else begin
        check("R7 busy during operation", {31'd0, req_ready}, 32'd0);
        check({tv, " read strobe timing"}, {31'd0, rd_valid},
              {31'd0, (op != 2'b01) && (i >= LAT + 1) && (i <= LAT + beats)});
        check("R6 write ack timing", {31'd0, wr_ack},
              {31'd0, (op == 2'b01) && (i == LAT + 1)});
        if (rd_valid) begin
          check("R4 R1 read word data", {16'd0, rd_data},
                {16'd0, model[base + ADDR_W'(i - LAT - 1)]});
          check({tv, " last flag"}, {31'd0, rd_last}, {31'd0, i == LAT + beats});
        end
      end
    end
    if (op == 2'b01) model[a] = d;
  endtask

  initial begin
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R2 no read after reset", {31'd0, rd_valid | rd_last}, 32'd0);
    check("R2 no ack after reset", {31'd0, wr_ack}, 32'd0);
    check("R2 counts cleared", {16'd0, cyc_count, cyc_serial}, 32'd0);

    // fill every word (R1, R6)
    for (int a = 0; a < DEPTH; a++) begin
      run_op(2'b01, ADDR_W'(a), DATA_W'($urandom), 1'b0, '0);
    end

    // directed corners
    run_op(2'b10, 8'h00, '0, 1'b0, '0);       // R3 first line
    run_op(2'b11, 8'hF8, '0, 1'b0, '0);       // R9 alt encoding, last line
    run_op(2'b10, 8'h13, '0, 1'b0, '0);       // R4 misaligned address
    run_op(2'b00, 8'hFF, '0, 1'b0, '0);       // R5 bank 3, top row
    run_op(2'b00, 8'h01, '0, 1'b0, '0);       // R5 bank 1
    run_op(2'b10, 8'h40, '0, 1'b1, 8'h42);    // R7 write while busy
    @(negedge clk);
    check("R7 ignored request started nothing", {31'd0, req_ready & ~wr_ack}, 32'd1);
    run_op(2'b00, 8'h42, '0, 1'b0, '0);       // R7 location unchanged
    run_op(2'b01, 8'h85, 16'h1234, 1'b0, '0); // R6 lone write
    run_op(2'b10, 8'h80, '0, 1'b0, '0);       // R6 neighbours intact

    // constrained random mix
    for (int k = 0; k < 150; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run_op(op, ADDR_W'($urandom), DATA_W'($urandom), 1'b0, '0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R3 R7: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule